// File: doc/BRIEF.md
# Multi-Ratio Deserializer With Bypass

This block turns one serial bit stream per lane into parallel words of 4, 7 or 8 bits. All lanes share a bit-rate clock enable and a frame strobe. The frame strobe marks the slow reference edge, which comes once every ratio bits. The bit that arrives while the strobe is high is frame position 0. Each word begins two bit periods after that edge, at frame position 2, so the slip caused by clock insertion delay is absorbed here. The first bit of a word is its most significant bit.

A mode input selects one of three ratios or a one-to-one pass mode. In pass mode every accepted serial bit goes straight to bit 0 of the output register. A new mode is sampled at reset and afterwards only on a bit that carries the frame strobe. Any partial word is discarded when the mode changes or when the framing moves. Downstream logic reads the parallel words on the cycle the shared valid strobe is high.

Top module: `mr_deser`

## Requirements
- R1: While reset is held (synchronous, active high), and after it is released, every word output is zero and `par_vld` is low until a word completes.
- R2: Mode 3 (ratio 8). The bit accepted two bits after a frame-strobe bit is bit 7 of the next word. The following seven bits fill bits 6 down to 0.
- R3: Mode 2 (ratio 7). Words are 7 bits wide, first bit in bit 6, and output bit 7 is zero.
- R4: Mode 1 (ratio 4). Words are 4 bits wide, first bit in bit 3, and output bits 7..4 are zero.
- R5: `par_vld` is high for exactly one cycle per completed word. That cycle directly follows the accepted bit that completes the word.
- R6: A cycle with `bit_en` low shifts no bit, advances no framing and changes no mode. A stream with idle cycles between its bits gives the same words as the same stream without them.
- R7: Mode 0 (pass). Every accepted bit appears in bit 0 of its lane's word, with bits 7..1 zero, and `par_vld` pulses once for each accepted bit.
- R8: A change on `mode_sel` on a bit without the frame strobe has no effect. The new mode takes hold on the next frame-strobe bit, and the bits of an unfinished word are dropped.
- R9: After reset, in modes 1 to 3, no word is produced until a frame strobe has been seen.
- R10: A frame strobe that lands off the expected position realigns the framing and produces no word on that bit, even if that bit would have completed a word. The next word starts two bits later.
- R11: Each lane deserializes its own input independently, with the shared framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One serial bit is accepted on each lane in this cycle |
| frame_stb | input | 1 | Marks the accepted bit as frame position 0 (slow clock edge) |
| mode_sel | input | 2 | 0 pass, 1 ratio 4, 2 ratio 7, 3 ratio 8 |
| ser_in | input | NCH | Serial input, one bit per lane |
| par_out | output | NCH*8 | Parallel word per lane, lane n in bits 8n+7..8n |
| par_vld | output | 1 | One-cycle strobe: new words are on `par_out` |

## Verification
The collision that matters most is between a frame strobe and word completion. A frame strobe can arrive on the very bit that would otherwise finish a word. The bench provokes this by sending seven spare bits after a ratio-8 stream, so that the next stream's frame bit sits where the counter expects the last bit of a word. It passes only if that bit yields no word, and if the following stream delivers exactly its own words, each starting two bits after the strobe. The same concern is tested with a mode change that shares a strobe with a pending partial word: the bench counts the pulses and requires that no stale word appears.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  // Widest word any mode produces; the mode set is fixed, so is this.
  localparam int MAX_W = 8;
  // Framing counter width, enough to hold indices up to MAX_W-1 plus anchors.
  localparam int CNT_W = $clog2(MAX_W) + 1;

  typedef enum logic [1:0] {
    MD_PASS = 2'd0,
    MD_R4   = 2'd1,
    MD_R7   = 2'd2,
    MD_R8   = 2'd3
  } mrd_mode_e;

  function automatic logic [CNT_W-1:0] mode_ratio(input mrd_mode_e m);
    case (m)
      MD_R4:   return CNT_W'(4);
      MD_R7:   return CNT_W'(7);
      MD_R8:   return CNT_W'(8);
      default: return CNT_W'(1);
    endcase
  endfunction

  function automatic logic [MAX_W-1:0] mode_mask(input mrd_mode_e m);
    logic [MAX_W:0] one_hot;
    one_hot = (MAX_W+1)'(1) << mode_ratio(m);
    return MAX_W'(one_hot - (MAX_W+1)'(1));
  endfunction

endpackage

// File: rtl/mrd_frame_ctl.sv
module mrd_frame_ctl
  import mrd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             frame_stb,
  input  mrd_mode_e        mode_sel,
  output logic             shift_en,
  output logic             capture,
  output logic [MAX_W-1:0] cap_mask
);

  mrd_mode_e        mode_q, mode_eff;
  logic [CNT_W-1:0] cnt_q, idx, ratio_eff, last_idx, anchor_idx;
  logic             locked_q, started_q;
  logic             frame_acc, pass_eff, realign, at_last;

  always_comb begin
    frame_acc  = bit_en && frame_stb;
    mode_eff   = frame_acc ? mode_sel : mode_q;
    ratio_eff  = mode_ratio(mode_eff);
    pass_eff   = (mode_eff == MD_PASS);
    last_idx   = ratio_eff - CNT_W'(1);
    // Frame bit sits two bits ahead of the word's first bit.
    anchor_idx = ratio_eff - CNT_W'(2);
    idx        = frame_acc ? anchor_idx : cnt_q;
    at_last    = (idx == last_idx);
    realign    = frame_acc && (!locked_q || (mode_sel != mode_q) || (cnt_q != anchor_idx));
    capture    = bit_en && (pass_eff || (locked_q && started_q && !frame_acc && at_last));
    shift_en   = bit_en;
    cap_mask   = mode_mask(mode_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= mode_sel;
      cnt_q     <= '0;
      locked_q  <= 1'b0;
      started_q <= 1'b0;
    end else if (bit_en) begin
      mode_q   <= mode_eff;
      locked_q <= locked_q | frame_stb;
      if (pass_eff || at_last) cnt_q <= '0;
      else                     cnt_q <= idx + CNT_W'(1);
      if (pass_eff || realign)                started_q <= 1'b0;
      else if (locked_q && (idx == CNT_W'(0))) started_q <= 1'b1;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(cnt_q) && $stable(started_q)));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bit_en && frame_stb) |=> $stable(mode_q));

  // R9
  unlocked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked_q && !frame_stb && mode_q != MD_PASS) |-> !capture);

  // R10
  realign_no_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && frame_stb && mode_sel != MD_PASS) |-> !capture);

endmodule

// File: rtl/mrd_lane.sv
module mrd_lane
  import mrd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             capture,
  input  logic [MAX_W-1:0] cap_mask,
  input  logic             din,
  output logic [MAX_W-1:0] word
);

  logic [MAX_W-2:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
      word <= '0;
    end else begin
      if (shift_en) sr_q <= {sr_q[MAX_W-3:0], din};
      if (capture)  word <= {sr_q, din} & cap_mask;
    end
  end

  // R3 R4 R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> ((word & ~$past(cap_mask)) == '0));

endmodule

// File: rtl/mr_deser.sv
module mr_deser
  import mrd_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               frame_stb,
  input  logic [1:0]         mode_sel,
  input  logic [NCH-1:0]     ser_in,
  output logic [NCH*8-1:0]   par_out,
  output logic               par_vld
);

  localparam int LW = MAX_W;

  logic             shift_en, capture;
  logic [LW-1:0]    cap_mask;

  mrd_frame_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .frame_stb(frame_stb),
    .mode_sel (mrd_mode_e'(mode_sel)),
    .shift_en (shift_en),
    .capture  (capture),
    .cap_mask (cap_mask)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    mrd_lane u_lane (
      .clk     (clk),
      .rst     (rst),
      .shift_en(shift_en),
      .capture (capture),
      .cap_mask(cap_mask),
      .din     (ser_in[g]),
      .word    (par_out[g*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) par_vld <= 1'b0;
    else     par_vld <= capture;
  end

  // R5
  vld_src_chk: assert property (@(posedge clk) disable iff (rst)
    par_vld |-> $past(bit_en));

endmodule

// File: tb/tb_mr_deser.sv
`timescale 1ns/1ps
module tb_mr_deser;

  localparam int NCH = 4;
  localparam int W   = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bit_en = 1'b0;
  logic               frame_stb = 1'b0;
  logic [1:0]         mode_sel = 2'd3;
  logic [NCH-1:0]     ser_in = '0;
  logic [NCH*W-1:0]   par_out;
  logic               par_vld;

  int total = 0;
  int bad   = 0;
  int cap_n = 0;
  logic [NCH*W-1:0] cap [64];

  always #2.5 clk = ~clk;

  mr_deser #(.NCH(NCH)) dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_stb(frame_stb),
    .mode_sel(mode_sel), .ser_in(ser_in), .par_out(par_out), .par_vld(par_vld)
  );

  // Vector fields: mode[14:13] nwords[12:9] gap[8] seed[7:0]
  localparam logic [14:0] VEC [6] = '{
    {2'd3, 4'd3, 1'b0, 8'hA5},
    {2'd2, 4'd3, 1'b0, 8'h3C},
    {2'd1, 4'd4, 1'b0, 8'hC6},
    {2'd3, 4'd2, 1'b1, 8'h5A},
    {2'd2, 4'd2, 1'b1, 8'hE1},
    {2'd1, 4'd3, 1'b1, 8'h7F}
  };

  always @(negedge clk) begin
    if (!rst && par_vld) begin
      if (cap_n < 64) cap[cap_n] = par_out;
      cap_n = cap_n + 1;
    end
  end

  function automatic int ratio_of(input logic [1:0] md);
    case (md)
      2'd1:    return 4;
      2'd2:    return 7;
      2'd3:    return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_word(input logic [7:0] seed, input int c, input int j, input int r);
    logic [7:0] v;
    logic [8:0] m;
    v = seed + 8'(c * 29) + 8'(j * 71);
    m = (9'd1 << r) - 9'd1;
    return v & m[7:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic frm, input logic [1:0] md, input logic [NCH-1:0] b);
    @(negedge clk);
    bit_en = 1'b1; frame_stb = frm; mode_sel = md; ser_in = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b0; frame_stb = 1'b0;
    end
  endtask

  task automatic do_reset(input logic [1:0] md, input logic chk);
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; frame_stb = 1'b0; mode_sel = md;
    @(negedge clk);
    @(negedge clk);
    if (chk) begin
      check("R1 word", 32'(par_out), 32'd0);
      check("R1 vld", 32'(par_vld), 32'd0);
    end
    rst = 1'b0;
  endtask

  // Stream framed at ratio of md_frame; non-frame bits drive md_off on mode_sel.
  task automatic run_stream(input string tag, input logic [1:0] md_frame, input logic [1:0] md_off,
                            input int nw, input logic [7:0] seed, input logic gap, input int extra);
    int r;
    int nbits;
    logic [NCH-1:0] b;
    logic [7:0] w;
    r = ratio_of(md_frame);
    nbits = 2 + nw * r;
    cap_n = 0;
    for (int p = 0; p < nbits; p++) begin
      for (int c = 0; c < NCH; c++) begin
        if (p < 2) b[c] = 1'b1;
        else begin
          w = exp_word(seed, c, (p - 2) / r, r);
          b[c] = w[r - 1 - ((p - 2) % r)];
        end
      end
      if (p % r == 0) put_bit(1'b1, md_frame, b);
      else            put_bit(1'b0, md_off, b);
      if (gap) idle(1);
    end
    for (int k = 0; k < extra; k++) put_bit(1'b0, md_off, '1);
    idle(3);
    check({tag, " R5 count"}, 32'(cap_n), 32'(nw));
    for (int j = 0; j < nw && j < 64; j++)
      for (int c = 0; c < NCH; c++)
        check({tag, " R11 lane word"}, 32'(cap[j][c*W +: W]), 32'(exp_word(seed, c, j, r)));
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NCH-1:0] pb;
    do_reset(2'd3, 1'b1);

    // Table walk: R2 (mode 3), R3 (mode 2), R4 (mode 1); gap entries cover R6.
    for (int v = 0; v < 6; v++) begin
      do_reset(VEC[v][14:13], 1'b0);
      case (VEC[v][14:13])
        2'd3:    run_stream(VEC[v][8] ? "R2 R6" : "R2", VEC[v][14:13], VEC[v][14:13], int'(VEC[v][12:9]), VEC[v][7:0], VEC[v][8], 0);
        2'd2:    run_stream(VEC[v][8] ? "R3 R6" : "R3", VEC[v][14:13], VEC[v][14:13], int'(VEC[v][12:9]), VEC[v][7:0], VEC[v][8], 0);
        default: run_stream(VEC[v][8] ? "R4 R6" : "R4", VEC[v][14:13], VEC[v][14:13], int'(VEC[v][12:9]), VEC[v][7:0], VEC[v][8], 0);
      endcase
    end

    // R1: outputs hold data now; reset must clear them.
    do_reset(2'd3, 1'b1);

    // R9: bits without any frame strobe yield nothing.
    cap_n = 0;
    for (int p = 0; p < 20; p++) put_bit(1'b0, 2'd3, 4'(p * 7 + 1));
    idle(3);
    check("R9 no lock count", 32'(cap_n), 32'd0);

    // R7: pass mode, one word per accepted bit.
    do_reset(2'd0, 1'b0);
    cap_n = 0;
    for (int k = 0; k < 6; k++) put_bit(1'b0, 2'd0, 4'(k * 5 + 3));
    idle(3);
    check("R7 count", 32'(cap_n), 32'd6);
    for (int k = 0; k < 6 && k < cap_n; k++) begin
      pb = 4'(k * 5 + 3);
      for (int c = 0; c < NCH; c++)
        check("R7 word", 32'(cap[k][c*W +: W]), {31'd0, pb[c]});
    end

    // R8: off-frame mode change ignored; frame-borne change drops the partial word.
    do_reset(2'd3, 1'b0);
    run_stream("R8 hold", 2'd3, 2'd1, 2, 8'h33, 1'b0, 3);
    run_stream("R8 switch", 2'd1, 2'd1, 2, 8'h9C, 1'b0, 0);

    // R10: frame strobe lands on the bit that would complete a word.
    do_reset(2'd3, 1'b0);
    run_stream("R10 pre", 2'd3, 2'd3, 1, 8'h11, 1'b0, 7);
    run_stream("R10 realign", 2'd3, 2'd3, 2, 8'hEE, 1'b0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule